// File: doc/BRIEF.md
# Command-Only Read Chunk Sequencer

This block takes a memory command that carries no data flits of its own and turns it into a paced series of burst-sized chunk requests for a per-channel scheduler. The work size is the command's byte count, or, when that is zero, the byte count of the request behind it. The block divides the work into bursts and spreads their issue evenly over a given drain time, so that the chunks follow the rate at which data would arrive. Each chunk carries its own address. The channel index comes from that address, so one long command stripes across the channels over time.

A fixed decode overhead runs once, before any chunk. For every accepted chunk the scheduler returns how many cycles remain until that chunk finishes. After the last chunk, the block waits for the latest of those finish points and then pulses `done`. Only one command is in flight at a time. `cmd_ready` stays low from acceptance until after the done pulse.

Top module: `cmd_chunk_seq`

## Requirements
- R1: The work size is `cmd_bytes` when that is nonzero, and `req_bytes` otherwise.
- R2: The chunk count is ceil(work / 2^BURST_LG). It is 16-byte bursts by default, and the count is zero for a zero work size.
- R3: Chunk k carries address (cmd_addr + k·2^BURST_LG) modulo 2^ADDR_W. Its channel `chk_chan` is address bits [BURST_LG+CHAN_LG-1:BURST_LG], which are bits [5:4] by default.
- R4: The interval is floor(cmd_drain / count). After each chunk handshake, the next `chk_valid` rises exactly interval+1 cycles later.
- R5: The overhead of OVERHEAD cycles is applied once, before the chunk phase. The first `chk_valid` appears OVERHEAD + DRAIN_W + 2 + interval cycles after the accept cycle.
- R6: With a chunk count of zero, no chunk is issued and `done` appears OVERHEAD+1 cycles after the accept cycle.
- R7: A chunk accepted in cycle h with returned delay d finishes in cycle h+d. `done` is a one-cycle pulse, exactly 2 cycles after the latest finish of the command.
- R8: While `chk_valid` is high and `chk_ready` is low, the chunk request is held unchanged.
- R9: `cmd_ready` is low from the cycle after acceptance through the done cycle, and high again in the cycle after `done`.
- R10: `chk_write` equals the `cmd_write` value captured with the command.
- R11: During and right after reset, `cmd_ready` is 1 and `chk_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_addr | input | ADDR_W | Base byte address |
| cmd_bytes | input | BYTES_W | Command byte count |
| req_bytes | input | BYTES_W | Request byte count, used when cmd_bytes is zero |
| cmd_drain | input | DRAIN_W | Drain time in cycles |
| cmd_write | input | 1 | Direction of the command |
| chk_valid | output | 1 | Chunk request offered |
| chk_ready | input | 1 | Scheduler takes the chunk |
| chk_addr | output | ADDR_W | Chunk address |
| chk_chan | output | CHAN_LG | Channel index of the chunk |
| chk_write | output | 1 | Chunk direction |
| chk_fin_dly | input | FIN_W | Cycles until the accepted chunk finishes |
| done | output | 1 | Command complete pulse |

## Verification
The bench sweeps command sizes across burst boundaries and tries drain times both smaller and larger than the chunk count. A design with an off-by-one ceiling would issue one chunk too many or too few. A design that rounded the interval up, or kept a zero quotient, would show a wrong gap between chunks. It keeps `req_bytes` large while `cmd_bytes` is nonzero, so choosing the wrong size source changes the chunk count. It also stalls the scheduler handshake and returns finish delays that make an earlier chunk outlast the last one. A design that waited only for the last chunk would then pulse `done` too early. An address sequence that crosses the top of the address space checks the wrap of the chunk address and its channel.

// File: rtl/cmd_chunk_pkg.sv
package cmd_chunk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OVH,
    ST_DIV,
    ST_GAP,
    ST_ISSUE,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/chunk_wait_counter.sv
module chunk_wait_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load || tick)
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/chunk_interval_div.sv
module chunk_interval_div #(
  parameter int DVD_W = 10,
  parameter int DVS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic [DVD_W-1:0] quotient
);
  localparam int STEP_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0]  quo_q, quo_d;
  logic [DVS_W-1:0]  rem_q, rem_d;
  logic [DVS_W-1:0]  dvs_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DVS_W:0]    rem_sh;
  logic              fits;

  always_comb begin
    rem_sh = {rem_q, quo_q[DVD_W-1]};
    fits   = (rem_sh >= {1'b0, dvs_q});
    quo_d  = quo_q;
    rem_d  = rem_q;
    step_d = step_q;
    if (start) begin
      quo_d  = dividend;
      rem_d  = '0;
      step_d = STEP_W'(DVD_W);
    end else if (busy) begin
      quo_d  = {quo_q[DVD_W-2:0], fits};
      rem_d  = fits ? DVS_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DVS_W-1:0];
      step_d = step_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
    end else if (start || busy) begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      step_q <= step_d;
      if (start)
        dvs_q <= divisor;
    end
  end

  assign busy     = (step_q != '0);
  assign quotient = quo_q;
endmodule

// File: rtl/chunk_finish_tracker.sv
module chunk_finish_tracker #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] fin_dly,
  output logic         settled
);
  logic [W-1:0] left_q, left_d, decayed;

  always_comb begin
    decayed = (left_q != '0) ? left_q - 1'b1 : '0;
    left_d  = decayed;
    if (accept && (fin_dly > decayed))
      left_d = fin_dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (accept || (left_q != '0))
      left_q <= left_d;
  end

  assign settled = (left_q == '0);
endmodule

// File: rtl/cmd_chunk_seq.sv
module cmd_chunk_seq #(
  parameter int ADDR_W   = 16,
  parameter int BYTES_W  = 12,
  parameter int DRAIN_W  = 10,
  parameter int BURST_LG = 4,
  parameter int CHAN_LG  = 2,
  parameter int FIN_W    = 6,
  parameter int OVERHEAD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [BYTES_W-1:0] cmd_bytes,
  input  logic [BYTES_W-1:0] req_bytes,
  input  logic [DRAIN_W-1:0] cmd_drain,
  input  logic               cmd_write,
  output logic               chk_valid,
  input  logic               chk_ready,
  output logic [ADDR_W-1:0]  chk_addr,
  output logic [CHAN_LG-1:0] chk_chan,
  output logic               chk_write,
  input  logic [FIN_W-1:0]   chk_fin_dly,
  output logic               done
);
  import cmd_chunk_pkg::*;

  localparam int CNT_W = BYTES_W - BURST_LG + 1;
  localparam int BURST = 1 << BURST_LG;
  localparam logic HAS_OVH = (OVERHEAD > 0);
  localparam logic [DRAIN_W-1:0] OVH_LOAD =
    (OVERHEAD > 0) ? DRAIN_W'(OVERHEAD - 1) : '0;

  seq_state_e state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, idx_q, idx_d;
  logic [DRAIN_W-1:0] drain_q;
  logic               dir_q;

  logic [BYTES_W-1:0] work_bytes;
  logic [BYTES_W:0]   work_round;
  logic [CNT_W-1:0]   new_cnt;
  logic               accept;

  logic               wc_load, wc_tick, wc_expired;
  logic [DRAIN_W-1:0] wc_val;
  logic               div_start, div_busy;
  logic [DRAIN_W-1:0] div_dividend, interval;
  logic [CNT_W-1:0]   div_divisor;
  logic               hs, trk_settled;

  // work size and chunk count of an offered command
  always_comb begin
    work_bytes = (cmd_bytes != '0) ? cmd_bytes : req_bytes;
    work_round = {1'b0, work_bytes} + (BYTES_W + 1)'(BURST - 1);
    new_cnt    = work_round[BURST_LG +: CNT_W];
  end

  assign accept       = (state_q == ST_IDLE) && cmd_valid;
  assign hs           = (state_q == ST_ISSUE) && chk_ready;
  assign div_dividend = (state_q == ST_IDLE) ? cmd_drain : drain_q;
  assign div_divisor  = (state_q == ST_IDLE) ? new_cnt : cnt_q;

  chunk_wait_counter #(.W(DRAIN_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wc_load),
    .load_val (wc_val),
    .tick     (wc_tick),
    .expired  (wc_expired)
  );

  chunk_interval_div #(.DVD_W(DRAIN_W), .DVS_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_dividend),
    .divisor  (div_divisor),
    .busy     (div_busy),
    .quotient (interval)
  );

  chunk_finish_tracker #(.W(FIN_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (hs),
    .fin_dly (chk_fin_dly),
    .settled (trk_settled)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    wc_load   = 1'b0;
    wc_val    = '0;
    wc_tick   = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          addr_d = cmd_addr;
          cnt_d  = new_cnt;
          idx_d  = '0;
          if (HAS_OVH) begin
            state_d = ST_OVH;
            wc_load = 1'b1;
            wc_val  = OVH_LOAD;
          end else if (new_cnt == '0) begin
            state_d = ST_DONE;
          end else begin
            state_d   = ST_DIV;
            div_start = 1'b1;
          end
        end
      end
      ST_OVH: begin
        if (!wc_expired) begin
          wc_tick = 1'b1;
        end else if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          state_d   = ST_DIV;
          div_start = 1'b1;
        end
      end
      ST_DIV: begin
        if (!div_busy) begin
          if (interval == '0) begin
            state_d = ST_ISSUE;
          end else begin
            state_d = ST_GAP;
            wc_load = 1'b1;
            wc_val  = interval - 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (wc_expired)
          state_d = ST_ISSUE;
        else
          wc_tick = 1'b1;
      end
      ST_ISSUE: begin
        if (chk_ready) begin
          idx_d  = idx_q + 1'b1;
          addr_d = addr_q + ADDR_W'(BURST);
          if (idx_q == cnt_q - 1'b1) begin
            state_d = ST_DRAIN;
          end else if (interval == '0) begin
            state_d = ST_ISSUE;
          end else begin
            state_d = ST_GAP;
            wc_load = 1'b1;
            wc_val  = interval - 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (trk_settled)
          state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      drain_q <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept || hs) begin
        addr_q <= addr_d;
        idx_q  <= idx_d;
      end
      if (accept) begin
        cnt_q   <= cnt_d;
        drain_q <= cmd_drain;
        dir_q   <= cmd_write;
      end
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign chk_valid = (state_q == ST_ISSUE);
  assign chk_addr  = addr_q;
  assign chk_chan  = addr_q[BURST_LG +: CHAN_LG];
  assign chk_write = dir_q;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/cmd_chunk_seq_chk.sv
module cmd_chunk_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int BURST_LG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic [ADDR_W-1:0] chk_addr,
  input logic              chk_write,
  input logic              done
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (done) begin
      seen_q <= 1'b0;
    end else if (chk_valid && chk_ready) begin
      seen_q <= 1'b1;
      last_q <= chk_addr;
    end
  end

  a_r3_addr_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_ready && seen_q) |->
      (chk_addr == last_q + ADDR_W'(1 << BURST_LG)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |=>
      (chk_valid && $stable(chk_addr) && $stable(chk_write)));

  a_r9_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r9_issue_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !cmd_ready);

  a_r6_done_without_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chk_valid);
endmodule

bind cmd_chunk_seq cmd_chunk_seq_chk #(
  .ADDR_W   (ADDR_W),
  .BURST_LG (BURST_LG)
) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .chk_valid (chk_valid),
  .chk_ready (chk_ready),
  .chk_addr  (chk_addr),
  .chk_write (chk_write),
  .done      (done)
);

// File: tb/tb_cmd_chunk_seq.sv
module tb_cmd_chunk_seq;
  localparam int ADDR_W = 16, BYTES_W = 12, DRAIN_W = 10;
  localparam int BURST_LG = 4, CHAN_LG = 2, FIN_W = 6, OVERHEAD = 2;
  localparam int BURST = 1 << BURST_LG;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready, cmd_write;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [BYTES_W-1:0] cmd_bytes, req_bytes;
  logic [DRAIN_W-1:0] cmd_drain;
  logic chk_valid, chk_ready, chk_write, done;
  logic [ADDR_W-1:0]  chk_addr;
  logic [CHAN_LG-1:0] chk_chan;
  logic [FIN_W-1:0]   chk_fin_dly;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  cmd_chunk_seq #(
    .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .DRAIN_W(DRAIN_W),
    .BURST_LG(BURST_LG), .CHAN_LG(CHAN_LG), .FIN_W(FIN_W), .OVERHEAD(OVERHEAD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .req_bytes(req_bytes),
    .cmd_drain(cmd_drain), .cmd_write(cmd_write), .chk_valid(chk_valid),
    .chk_ready(chk_ready), .chk_addr(chk_addr), .chk_chan(chk_chan),
    .chk_write(chk_write), .chk_fin_dly(chk_fin_dly), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input int base, input int cb, input int rb,
                         input int drain, input bit wr, input bit stall);
    int work, cnt, iv, k, h_prev, fin, t;
    bit pend, got_done;
    work = (cb != 0) ? cb : rb;                       // R1
    cnt  = (work + BURST - 1) / BURST;                // R2
    iv   = (cnt != 0) ? drain / cnt : 0;              // R4
    @(negedge clk);
    check(cmd_ready == 1'b1, "R9 idle ready", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = ADDR_W'(base); cmd_bytes = BYTES_W'(cb);
    req_bytes = BYTES_W'(rb); cmd_drain = DRAIN_W'(drain); cmd_write = wr;
    chk_ready = 1'b0; chk_fin_dly = '0;
    k = 0; h_prev = 0; fin = 0; pend = 0; got_done = 0;
    for (t = 1; t < 20000; t++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      chk_ready = 1'b0;
      if (t == 1) check(cmd_ready == 1'b0, "R9 busy after accept", cmd_ready, 0);
      if (chk_valid) begin
        int ea;
        ea = (base + k * BURST) % (1 << ADDR_W);
        if (!pend) begin
          if (k == 0)
            check(t == OVERHEAD + DRAIN_W + 2 + iv, "R5 first chunk time", t,
                  OVERHEAD + DRAIN_W + 2 + iv);
          else
            check(t - h_prev == iv + 1, "R4 chunk gap", t - h_prev, iv + 1);
          check(int'(chk_addr) == ea, "R3 chunk address", chk_addr, ea);
          check(int'(chk_chan) == ((ea >> BURST_LG) & 3), "R3 channel", chk_chan,
                (ea >> BURST_LG) & 3);
          check(chk_write == wr, "R10 direction", chk_write, wr);
          check(k < cnt, "R2 chunk count bound", k + 1, cnt);
        end else begin
          check(int'(chk_addr) == ea, "R8 held request", chk_addr, ea);
        end
        if (!stall || (t % 3) == 1) begin
          int d;
          d = (k * 7 + drain) % 29;
          chk_ready = 1'b1;
          chk_fin_dly = FIN_W'(d);
          if (t + d > fin) fin = t + d;
          h_prev = t; k++; pend = 0;
        end else begin
          pend = 1;
        end
      end
      if (done) begin
        got_done = 1;
        check(k == cnt, "R2 chunks issued", k, cnt);
        if (cnt == 0)
          check(t == OVERHEAD + 1, "R6 zero-count done time", t, OVERHEAD + 1);
        else
          check(t == fin + 2, "R7 done after latest finish", t, fin + 2);
        check(chk_valid == 1'b0, "R6 no chunk with done", chk_valid, 0);
        break;
      end
      if (finished) break;
    end
    if (!got_done) check(0, "R7 done missing", 0, 1);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", done, 0);
    check(cmd_ready == 1'b1, "R9 ready after done", cmd_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int drains [4];
    drains[0] = 0; drains[1] = 7; drains[2] = 60; drains[3] = 301;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_bytes = '0;
    req_bytes = '0; cmd_drain = '0; cmd_write = 1'b0; chk_ready = 1'b0;
    chk_fin_dly = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmd_ready == 1'b1 && chk_valid == 1'b0 && done == 1'b0, "R11 in reset",
          {cmd_ready, chk_valid, done}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && chk_valid == 1'b0 && done == 1'b0, "R11 after reset",
          {cmd_ready, chk_valid, done}, 4);
    // sweep of sizes across burst edges with a large request size (R1, R2)
    for (int di = 0; di < 4; di++)
      for (int cb = 0; cb <= 72; cb++)
        run_cmd(cb * 48 + di * 1024, cb, 200, drains[di], cb[0], cb[1]);
    // zero command size: request size used, including zero (R1, R6)
    run_cmd(16'h0100, 0, 0, 50, 1'b0, 1'b0);
    run_cmd(16'h0100, 0, 1, 50, 1'b1, 1'b0);
    run_cmd(16'h0100, 0, 17, 5, 1'b0, 1'b1);
    // address wrap across top of space (R3)
    run_cmd(16'hFFD0, 100, 0, 20, 1'b1, 1'b0);
    // drain smaller than chunk count: zero interval (R4)
    run_cmd(16'h0008, 160, 0, 3, 1'b0, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule